// File: doc/BRIEF.md
# Link Port Hot-Plug Controller

This block manages insertion, removal and software enable for one point-to-point link port. It filters the raw presence pin, then tracks the port through five states: absent, software-disabled, initialising, framing and active. From that state it produces two output-enable controls. One covers the port's data outputs and the other covers its sync clock output. It also produces a one-cycle pulse that starts the link initialisation sequence, and it turns requests aimed at a port that is down into master aborts.

Software uses a small four-entry register file:

| Address | Register | Bits |
|---|---|---|
| 0 | Control | bit 0 enable, bit 1 GPIO 0, bit 2 GPIO 1 |
| 1 | Interrupt status | bit 0 presence change, bit 1 idle change; write 1 to clear |
| 2 | Interrupt mask | bit 0 and bit 1 pass the matching status bit when 1 |
| 3 | Port status, read only | bits 2:0 state code, bit 3 filtered presence |

The state codes are 0 absent, 1 disabled, 2 init, 3 framing and 4 active. A single interrupt line is raised from the status bits that the mask lets through.

Top module: `hotplug_port_ctl`

## Requirements
- R1: The raw presence input passes through a two-flop synchronizer. The filtered presence follows the synchronized value only once that value has differed from it for 16 consecutive cycles. Shorter pulses have no effect.
- R2: While filtered presence is low, the state is 0 (absent) and both `dataOe` and `syncOe` are low.
- R3: While present with control bit 0 clear, the state is 1 (disabled), `syncOe` is high and `dataOe` is low.
- R4: `reqAbort` equals `reqValid` while the state is 0 or 1, and is low otherwise.
- R5: Once the port is present with control bit 0 set, it leaves state 0 or 1 for state 2 (init). `initStart` is high only in the first init cycle. Init lasts 4 cycles and then moves to state 3 (framing).
- R6: In framing, the port moves to state 4 (active) on the 8th consecutive cycle with `idleDet` high. A low cycle restarts the count.
- R7: In the active state, `rxCtrlSeen` returns the port to init. Clearing control bit 0 in init, framing or active gives state 1. Setting it again gives init.
- R8: Status bit 0 is set on every change of filtered presence, rising or falling.
- R9: Status bit 1 is set when `idleDet` changes value while the state is init or framing. An `idleDet` change in any other state leaves it unchanged.
- R10: Writing 1 to a status bit at address 1 clears it, and writing 0 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R11: `irq` is high exactly when some status bit is set whose mask bit at address 2 is 1.
- R12: `gpioOut[0]` follows control bit 1 and `gpioOut[1]` follows control bit 2.
- R13: `dataOe` is high in states 2, 3 and 4, and `syncOe` is high in every state except 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| presRaw | input | 1 | Unsynchronized presence pin |
| idleDet | input | 1 | Receiver sees the partner's idle pattern |
| rxCtrlSeen | input | 1 | Receiver decoded a partner init/control packet |
| reqValid | input | 1 | A request targets this port |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 3 | Register write data |
| regRdData | output | 4 | Register read data for regAddr |
| dataOe | output | 1 | Enable for the port's data outputs |
| syncOe | output | 1 | Enable for the sync clock output |
| initStart | output | 1 | Pulse that starts link initialisation |
| reqAbort | output | 1 | Current request completes as master abort |
| portState | output | 3 | State code |
| irq | output | 1 | Masked interrupt |
| gpioOut | output | 2 | Software-driven general-purpose outputs |

## Verification
The assertions check these properties on every cycle:
- the output-enable levels that belong to the absent and disabled states;
- that a loss of filtered presence forces the absent state one cycle later;
- that the init pulse lasts one cycle, that framing is entered only from init and that active is entered only from framing;
- that a status bit stays set until a matching write clears it.

Only the bench's scenarios can show certain behaviours. These are the debounce window rejecting short pulses, the exact eight-cycle idle run and its restart after a low cycle, and the idle interrupt being suppressed outside training. The same holds for the restart paths through `rxCtrlSeen` and the enable bit, and for the single-cycle interrupt when a set and a clear collide.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [2:0] {
    ST_ABSENT   = 3'd0,
    ST_DISABLED = 3'd1,
    ST_INIT     = 3'd2,
    ST_FRAMING  = 3'd3,
    ST_ACTIVE   = 3'd4
  } portState_e;

  // control -> datapath
  typedef struct packed {
    logic countInit;
    logic countIdle;
    logic training;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic presDb;
    logic enable;
    logic initFirst;
    logic initDone;
    logic idleRunDone;
  } dpFlags_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_MASK   = 2'd2;
  localparam logic [1:0] ADDR_PORT   = 2'd3;

  localparam int WR_W = 3;
  localparam int RD_W = 4;

endpackage

// File: rtl/hp_port_datapath.sv
module hp_port_datapath
  import hp_pkg::*;
#(
  parameter int DEB_CYCLES  = 16,
  parameter int INIT_CYCLES = 4,
  parameter int IDLE_RUN    = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            presRaw,
  input  logic            idleDet,
  input  logic            regWrEn,
  input  logic [1:0]      regAddr,
  input  logic [WR_W-1:0] regWrData,
  input  ctrlStrobe_t     strobe,
  output dpFlags_t        flags,
  output logic [2:0]      ctrlQ,
  output logic [1:0]      maskQ,
  output logic [1:0]      statusQ,
  output logic            irq
);

  localparam int DEB_W  = (DEB_CYCLES  > 1) ? $clog2(DEB_CYCLES)  : 1;
  localparam int INIT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam int RUN_W  = (IDLE_RUN    > 1) ? $clog2(IDLE_RUN)    : 1;
  localparam logic [DEB_W-1:0]  DEB_LAST  = DEB_W'(DEB_CYCLES - 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(IDLE_RUN - 1);

  logic [1:0]        syncQ;
  logic              presSync;
  logic [DEB_W-1:0]  debCnt;
  logic              presDbQ;
  logic              presPrevQ;
  logic [INIT_W-1:0] initCnt;
  logic [RUN_W-1:0]  idleRun;
  logic              idlePrevQ;
  logic [1:0]        statusNext;
  logic              wrCtrl, wrStatus, wrMask;

  assign presSync = syncQ[1];

  // presence synchronizer and debounce filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      debCnt    <= '0;
      presDbQ   <= 1'b0;
      presPrevQ <= 1'b0;
    end else begin
      syncQ     <= {syncQ[0], presRaw};
      presPrevQ <= presDbQ;
      if (presSync == presDbQ) begin
        debCnt <= '0;
      end else if (debCnt == DEB_LAST) begin
        presDbQ <= presSync;
        debCnt  <= '0;
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  // init timer and idle run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt   <= '0;
      idleRun   <= '0;
      idlePrevQ <= 1'b0;
    end else begin
      idlePrevQ <= idleDet;
      initCnt   <= strobe.countInit ? initCnt + 1'b1 : '0;
      if (strobe.countIdle && idleDet) begin
        if (idleRun != RUN_LAST) idleRun <= idleRun + 1'b1;
      end else begin
        idleRun <= '0;
      end
    end
  end

  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);
  assign wrMask   = regWrEn && (regAddr == ADDR_MASK);

  always_comb begin
    statusNext = statusQ;
    if (wrStatus) statusNext = statusNext & ~regWrData[1:0];
    if (presDbQ != presPrevQ) statusNext[0] = 1'b1;
    if (strobe.training && (idleDet != idlePrevQ)) statusNext[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= regWrData[2:0];
      if (wrMask) maskQ <= regWrData[1:0];
      statusQ <= statusNext;
    end
  end

  assign irq = |(statusQ & maskQ);

  assign flags.presDb      = presDbQ;
  assign flags.enable      = ctrlQ[0];
  assign flags.initFirst   = (initCnt == '0);
  assign flags.initDone    = (initCnt == INIT_LAST);
  assign flags.idleRunDone = idleDet && (idleRun == RUN_LAST);

endmodule

// File: rtl/hp_port_fsm.sv
module hp_port_fsm
  import hp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpFlags_t    flags,
  input  logic        rxCtrlSeen,
  input  logic        reqValid,
  output portState_e  stateQ,
  output ctrlStrobe_t strobe,
  output logic        dataOe,
  output logic        syncOe,
  output logic        initStart,
  output logic        reqAbort
);

  portState_e stateNext;
  logic portDown;

  always_comb begin
    stateNext = stateQ;
    if (!flags.presDb) begin
      stateNext = ST_ABSENT;
    end else if (!flags.enable) begin
      stateNext = ST_DISABLED;
    end else begin
      unique case (stateQ)
        ST_ABSENT, ST_DISABLED: stateNext = ST_INIT;
        ST_INIT:    if (flags.initDone)    stateNext = ST_FRAMING;
        ST_FRAMING: if (flags.idleRunDone) stateNext = ST_ACTIVE;
        ST_ACTIVE:  if (rxCtrlSeen)        stateNext = ST_INIT;
        default:    stateNext = ST_ABSENT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ABSENT;
    else       stateQ <= stateNext;
  end

  assign strobe.countInit = (stateQ == ST_INIT);
  assign strobe.countIdle = (stateQ == ST_FRAMING);
  assign strobe.training  = (stateQ == ST_INIT) || (stateQ == ST_FRAMING);

  assign portDown  = (stateQ == ST_ABSENT) || (stateQ == ST_DISABLED);
  assign dataOe    = !portDown;
  assign syncOe    = (stateQ != ST_ABSENT);
  assign initStart = (stateQ == ST_INIT) && flags.initFirst;
  assign reqAbort  = reqValid && portDown;

endmodule

// File: rtl/hotplug_port_ctl.sv
module hotplug_port_ctl
  import hp_pkg::*;
#(
  parameter int DEB_CYCLES  = 16,
  parameter int INIT_CYCLES = 4,
  parameter int IDLE_RUN    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       presRaw,
  input  logic       idleDet,
  input  logic       rxCtrlSeen,
  input  logic       reqValid,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [2:0] regWrData,
  output logic [3:0] regRdData,
  output logic       dataOe,
  output logic       syncOe,
  output logic       initStart,
  output logic       reqAbort,
  output logic [2:0] portState,
  output logic       irq,
  output logic [1:0] gpioOut
);

  ctrlStrobe_t strobe;
  dpFlags_t    flags;
  portState_e  stateQ;
  logic [2:0]  ctrlQ;
  logic [1:0]  maskQ;
  logic [1:0]  statusQ;

  hp_port_datapath #(
    .DEB_CYCLES (DEB_CYCLES),
    .INIT_CYCLES(INIT_CYCLES),
    .IDLE_RUN   (IDLE_RUN)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .presRaw  (presRaw),
    .idleDet  (idleDet),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobe   (strobe),
    .flags    (flags),
    .ctrlQ    (ctrlQ),
    .maskQ    (maskQ),
    .statusQ  (statusQ),
    .irq      (irq)
  );

  hp_port_fsm fsm_i (
    .clk       (clk),
    .rstN      (rstN),
    .flags     (flags),
    .rxCtrlSeen(rxCtrlSeen),
    .reqValid  (reqValid),
    .stateQ    (stateQ),
    .strobe    (strobe),
    .dataOe    (dataOe),
    .syncOe    (syncOe),
    .initStart (initStart),
    .reqAbort  (reqAbort)
  );

  assign portState = stateQ;
  assign gpioOut   = ctrlQ[2:1];

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdData = {1'b0, ctrlQ};
      ADDR_STATUS: regRdData = {2'b00, statusQ};
      ADDR_MASK:   regRdData = {2'b00, maskQ};
      default:     regRdData = {flags.presDb, stateQ};
    endcase
  end

endmodule

// File: rtl/hp_port_checker.sv
module hp_port_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] portState,
  input logic       dataOe,
  input logic       syncOe,
  input logic       initStart,
  input logic       reqAbort,
  input logic       reqValid,
  input logic       presDb,
  input logic [1:0] statusQ,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [2:0] regWrData
);

  localparam logic [2:0] S_ABS = 3'd0;
  localparam logic [2:0] S_DIS = 3'd1;
  localparam logic [2:0] S_INI = 3'd2;
  localparam logic [2:0] S_FRM = 3'd3;
  localparam logic [2:0] S_ACT = 3'd4;

  AST_PRES_LOSS_ABSENT: assert property (@(posedge clk) disable iff (!rstN)
    !presDb |=> portState == S_ABS); // R2

  AST_ABSENT_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    portState == S_ABS |-> !syncOe && !dataOe); // R2

  AST_DISABLED_SYNC_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    portState == S_DIS |-> syncOe && !dataOe); // R3

  AST_ABORT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqAbort |-> reqValid && !dataOe); // R4

  AST_INIT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    initStart |=> !initStart); // R5

  AST_FRAMING_FROM_INIT: assert property (@(posedge clk) disable iff (!rstN)
    (portState == S_FRM && $past(portState) != S_FRM) |-> $past(portState) == S_INI); // R5

  AST_ACTIVE_FROM_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    (portState == S_ACT && $past(portState) != S_ACT) |-> $past(portState) == S_FRM); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusQ[0]) && !$past(regWrEn && regAddr == 2'd1 && regWrData[0])) |-> statusQ[0]); // R10

endmodule

bind hotplug_port_ctl hp_port_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .portState(portState),
  .dataOe   (dataOe),
  .syncOe   (syncOe),
  .initStart(initStart),
  .reqAbort (reqAbort),
  .reqValid (reqValid),
  .presDb   (flags.presDb),
  .statusQ  (statusQ),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData)
);

// File: tb/hotplug_port_ctl_tb_top.sv
`timescale 1ns/1ps
module hotplug_port_ctl_tb_top;

  localparam int DEB_N  = 16;
  localparam int INIT_N = 4;
  localparam int RUN_N  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic presRaw = 1'b0, idleDet = 1'b0, rxCtrlSeen = 1'b0, reqValid = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [2:0] regWrData = 3'd0;
  logic [3:0] regRdData;
  logic dataOe, syncOe, initStart, reqAbort, irq;
  logic [2:0] portState;
  logic [1:0] gpioOut;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hotplug_port_ctl dut_i (
    .clk(clk), .rstN(rstN), .presRaw(presRaw), .idleDet(idleDet),
    .rxCtrlSeen(rxCtrlSeen), .reqValid(reqValid), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dataOe(dataOe), .syncOe(syncOe), .initStart(initStart),
    .reqAbort(reqAbort), .portState(portState), .irq(irq), .gpioOut(gpioOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mS1, mS2, mDb, mPres, mPresPrev, mState, mInit, mRun, mIdlePrev;
  int mCtrl, mMask, mStatus;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mDb = 0; mPres = 0; mPresPrev = 0; mState = 0;
      mInit = 0; mRun = 0; mIdlePrev = 0; mCtrl = 0; mMask = 0; mStatus = 0;
    end else begin
      automatic int nState = mState;
      automatic int nStatus = mStatus;
      automatic int nPres = mPres;
      automatic int nDb = mDb;
      automatic int nInit = (mState == 2) ? mInit + 1 : 0;
      automatic int nRun = 0;
      if (mState == 3 && idleDet) nRun = (mRun < RUN_N - 1) ? mRun + 1 : mRun;
      if (mPres == 0) nState = 0;
      else if ((mCtrl & 1) == 0) nState = 1;
      else if (mState <= 1) nState = 2;
      else if (mState == 2 && mInit == INIT_N - 1) nState = 3;
      else if (mState == 3 && idleDet && mRun == RUN_N - 1) nState = 4;
      else if (mState == 4 && rxCtrlSeen) nState = 2;
      if (regWrEn && regAddr == 2'd1) nStatus = nStatus & ~int'(regWrData[1:0]);
      if (mPres != mPresPrev) nStatus = nStatus | 1;
      if ((mState == 2 || mState == 3) && (int'(idleDet) != mIdlePrev)) nStatus = nStatus | 2;
      if (mS2 == mPres) nDb = 0;
      else if (mDb == DEB_N - 1) begin nPres = mS2; nDb = 0; end
      else nDb = mDb + 1;
      if (regWrEn && regAddr == 2'd0) mCtrl = int'(regWrData);
      if (regWrEn && regAddr == 2'd2) mMask = int'(regWrData[1:0]);
      mPresPrev = mPres;
      mPres = nPres; mDb = nDb;
      mS2 = mS1; mS1 = int'(presRaw);
      mState = nState; mInit = nInit; mRun = nRun;
      mStatus = nStatus; mIdlePrev = int'(idleDet);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      automatic int eRd;
      case (regAddr)
        2'd0: eRd = mCtrl;
        2'd1: eRd = mStatus;
        2'd2: eRd = mMask;
        default: eRd = (mPres << 3) | mState;
      endcase
      chk(int'(portState) == mState, "R6 portState", portState, mState);
      chk(syncOe == (mState != 0), "R3 syncOe", syncOe, mState != 0);
      chk(dataOe == (mState >= 2), "R13 dataOe", dataOe, mState >= 2);
      chk(initStart == (mState == 2 && mInit == 0), "R5 initStart", initStart, mState == 2 && mInit == 0);
      chk(reqAbort == (reqValid && mState <= 1), "R4 reqAbort", reqAbort, reqValid && mState <= 1);
      chk(irq == ((mStatus & mMask) != 0), "R11 irq", irq, (mStatus & mMask) != 0);
      chk(int'(gpioOut) == ((mCtrl >> 1) & 3), "R12 gpio", gpioOut, (mCtrl >> 1) & 3);
      chk(int'(regRdData) == eRd, "R10 regRdData", regRdData, eRd);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(1);
    regWrEn = 1'b0; regWrData = 3'd0;
  endtask

  task automatic waitState(input int s);
    for (int i = 0; i < 100; i++) begin
      if (int'(portState) == s) break;
      step(1);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int irqCycles;
    int initLen;
    step(3);
    rstN = 1'b1;
    step(1);
    @(negedge clk);
    chk(portState == 3'd0 && !syncOe && !dataOe && !irq, "R2 reset state", portState, 0);
    step(1);

    // R1: short presence pulse is ignored
    presRaw = 1'b1; step(5); presRaw = 1'b0; step(30);
    regAddr = 2'd1; step(1);
    chk(portState == 3'd0, "R1 glitch ignored state", portState, 0);
    chk(regRdData == 4'd0, "R1 glitch no presence event", regRdData, 0);

    // R3/R8: presence stable, enable clear
    presRaw = 1'b1; step(25);
    chk(portState == 3'd1 && syncOe && !dataOe, "R3 disabled keeps sync", portState, 1);
    chk(regRdData[0] == 1'b1, "R8 presence rise event", regRdData[0], 1);

    reqValid = 1'b1; step(1);
    chk(reqAbort == 1'b1, "R4 abort while disabled", reqAbort, 1);
    reqValid = 1'b0;

    // R11/R10: mask and write-one-to-clear
    wr(2'd2, 3'd1);
    chk(irq == 1'b1, "R11 masked source raises irq", irq, 1);
    wr(2'd1, 3'd0);
    regAddr = 2'd1; step(1);
    chk(regRdData[0] == 1'b1, "R10 write zero keeps bit", regRdData[0], 1);
    wr(2'd1, 3'd1);
    regAddr = 2'd1; step(1);
    chk(regRdData[0] == 1'b0 && !irq, "R10 write one clears", regRdData[0], 0);

    // R5/R12: enable with both GPIO bits
    wr(2'd0, 3'd7);
    chk(gpioOut == 2'd3, "R12 gpio follow control", gpioOut, 3);
    waitState(2);
    chk(initStart == 1'b1, "R5 init pulse first cycle", initStart, 1);
    initLen = 0;
    while (portState == 3'd2 && initLen < 20) begin initLen++; step(1); end
    chk(initLen == INIT_N, "R5 init duration", initLen, INIT_N);
    chk(portState == 3'd3, "R5 framing after init", portState, 3);

    // R6/R9: idle run with interruption, toggles set idle event
    idleDet = 1'b1; step(5);
    idleDet = 1'b0; step(1);
    chk(portState == 3'd3, "R6 broken run stays framing", portState, 3);
    idleDet = 1'b1; step(RUN_N - 1);
    chk(portState == 3'd3, "R6 seven cycles not enough", portState, 3);
    step(1);
    chk(portState == 3'd4 && dataOe, "R6 active after eight", portState, 4);
    chk(dataOe == 1'b1, "R13 data outputs on when active", dataOe, 1);
    regAddr = 2'd1; step(1);
    chk(regRdData[1] == 1'b1, "R9 idle change in training", regRdData[1], 1);
    wr(2'd1, 3'd2);
    idleDet = 1'b0; step(2); idleDet = 1'b1; step(2);
    regAddr = 2'd1; step(1);
    chk(regRdData[1] == 1'b0, "R9 idle change ignored when active", regRdData[1], 0);
    reqValid = 1'b1; step(1);
    chk(reqAbort == 1'b0, "R4 no abort when active", reqAbort, 0);
    reqValid = 1'b0;

    // R7: partner restart, local enable toggle
    rxCtrlSeen = 1'b1; step(1); rxCtrlSeen = 1'b0;
    chk(portState == 3'd2, "R7 partner restart to init", portState, 2);
    wr(2'd0, 3'd6); step(1);
    chk(portState == 3'd1 && gpioOut == 2'd3, "R7 enable clear disables", portState, 1);
    wr(2'd0, 3'd1); step(1);
    chk(portState == 3'd2 && gpioOut == 2'd0, "R7 re-enable restarts", portState, 2);

    // R2/R8/R10: presence loss while clear is held
    regWrEn = 1'b1; regAddr = 2'd1; regWrData = 3'd1;
    presRaw = 1'b0;
    irqCycles = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) irqCycles++;
      step(1);
    end
    regWrEn = 1'b0; regWrData = 3'd0;
    chk(irqCycles == 1, "R10 set wins over clear", irqCycles, 1);
    chk(portState == 3'd0 && !syncOe && !dataOe, "R2 absent tristates all", portState, 0);
    step(2);
    finishRun();
  end

endmodule